// File: doc/BRIEF.md
# Two-channel prescaled PWM controller

A register-mapped peripheral that drives two independent pulse-width-modulated outputs from a single input clock. Each channel divides the input clock by a divisor picked from a fixed table of non-power-of-two ratios. It counts prescaled ticks through a programmable period, and its output is active for a programmable number of ticks at the start of each period. Software programs the channels through a small word-addressed bus with one write strobe, an address, write data and combinational read data.

Period and active counts are double-buffered. A write lands in a shadow copy and raises a per-channel pending flag. The shadow moves into the working registers at the end of the current period, or on the next clock if the channel is idle. Each channel also has an output polarity select, which resets to the inverted sense. It has a clock gate that freezes the channel, a one-shot mode that emits a single period per trigger, and a bypass that routes the prescaled clock straight to the pin.

Top module: `pwm2_ctrl`

## Requirements
- R1: After reset the control word and both period words read 0, and both outputs are high, because the polarity bits are 0 and so inverted.
- R2: Word 0 is control. Channel n's fields start at bit 15*n: [3:0] prescaler code, bit 4 enable, bit 5 polarity (1 = active-high), bit 6 clock gate, bit 7 one-shot mode, bit 8 trigger, bit 9 bypass. Bit 28+n is channel n's read-only pending flag. Word 1+n is channel n's period register, with period-minus-one in [23:16] and active ticks in [7:0]. Writable fields read back as written.
- R3: Prescaler codes map to these divisors: 0..4 → 120, 180, 240, 360, 480; 8..12 → 12000, 24000, 36000, 48000, 72000; 15 → 1. A period lasts (P+1)*divisor input cycles. Codes 5, 6, 7, 13 and 14 stop the prescaler and freeze the output.
- R4: The output is active for the first D ticks of every period. D = 0 keeps it inactive, and D > P keeps it always active.
- R5: With polarity 0 the output is the logical inverse of its active-high value.
- R6: The counter advances only while both enable and gate are set. Clearing the gate freezes the output. Clearing enable drives the inactive level and restarts the channel from tick 0.
- R7: A period-register write sets the pending flag. The shadow moves into the working registers at the end of the current period, or one clock later if the channel is idle (disabled, or in one-shot mode without a trigger). The pending flag clears when that transfer happens.
- R8: With one-shot mode set, the output stays inactive until the trigger bit is written to 1. The channel then emits exactly one period, the trigger bit clears itself, and the output returns to inactive.
- R9: With bypass set, the output follows the prescaled clock. That clock toggles on every prescaled tick.
- R10: A period write in the same cycle as an end-of-period transfer loads the previous shadow, and the pending flag stays set for the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address (0 control, 1+n period of channel n) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pwm_o | output | 2 | PWM outputs, bit n for channel n |

## Verification
The delicate collision is a period-register write landing on the very clock where the running period ends and the shadow transfers. The bench tracks its reference model's tick counter and issues the write on exactly the cycle before the last tick is consumed. Correct behaviour is judged by three things: the pending flag stays set, the following period still has the old active count, and the new value governs only the period after that.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

  localparam int CH_STRIDE = 15;
  localparam int RDY_BASE  = 28;
  localparam int PRD_LSB   = 16;

  typedef struct packed {
    logic       bypass;
    logic       pulse;
    logic       mode;
    logic       gate;
    logic       act;
    logic       en;
    logic [3:0] presc;
  } ch_ctrl_t;

  function automatic logic [31:0] presc_div(input logic [3:0] code);
    case (code)
      4'd0:    presc_div = 32'd120;
      4'd1:    presc_div = 32'd180;
      4'd2:    presc_div = 32'd240;
      4'd3:    presc_div = 32'd360;
      4'd4:    presc_div = 32'd480;
      4'd8:    presc_div = 32'd12000;
      4'd9:    presc_div = 32'd24000;
      4'd10:   presc_div = 32'd36000;
      4'd11:   presc_div = 32'd48000;
      4'd12:   presc_div = 32'd72000;
      4'd15:   presc_div = 32'd1;
      default: presc_div = 32'd0; // reserved
    endcase
  endfunction

endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler
  import pwm2_pkg::*;
#(
  parameter int DIV_W = 17
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       run_i,
  input  logic [3:0] code_i,
  output logic       tick_o,
  output logic       pclk_o
);

  logic [DIV_W-1:0] div, pcnt_q;
  logic             valid;

  assign div    = DIV_W'(presc_div(code_i));
  assign valid  = (div != '0);
  assign tick_o = run_i && valid && (pcnt_q >= div - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      pclk_o <= 1'b0;
    end else if (!en_i) begin
      pcnt_q <= '0;
      pclk_o <= 1'b0;
    end else begin
      if (run_i && valid) pcnt_q <= tick_o ? '0 : pcnt_q + DIV_W'(1);
      if (tick_o)         pclk_o <= ~pclk_o;
    end
  end

  // R3
  reserved_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !valid) |=> ($stable(pcnt_q) && $stable(pclk_o)));

endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ch_ctrl_t         cfg_i,
  input  logic             prd_wr_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [CNT_W-1:0] dty_i,
  output logic             pwm_o,
  output logic             pend_o,
  output logic             done_o,
  output logic [CNT_W-1:0] shd_prd_o,
  output logic [CNT_W-1:0] shd_dty_o
);

  logic [CNT_W-1:0] cnt_q, prd_q, dty_q;
  logic             run, hold, idle, tick, pclk, eop, load, lvl;

  assign hold = cfg_i.mode && !cfg_i.pulse;
  assign run  = cfg_i.en && cfg_i.gate && !hold;
  assign idle = !cfg_i.en || hold;

  pwm2_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_i.en),
    .run_i  (run),
    .code_i (cfg_i.presc),
    .tick_o (tick),
    .pclk_o (pclk)
  );

  assign eop    = tick && (cnt_q == prd_q);
  assign done_o = eop && cfg_i.mode && cfg_i.pulse;
  assign load   = pend_o && (idle || eop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!cfg_i.en || hold)  cnt_q <= '0;
    else if (tick)               cnt_q <= eop ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q <= '0;
      dty_q <= '0;
    end else if (load) begin
      prd_q <= shd_prd_o;
      dty_q <= shd_dty_o;
    end
  end

  // a write in the load cycle wins the pending flag; the old shadow is loaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_prd_o <= '0;
      shd_dty_o <= '0;
      pend_o    <= 1'b0;
    end else if (prd_wr_i) begin
      shd_prd_o <= prd_i;
      shd_dty_o <= dty_i;
      pend_o    <= 1'b1;
    end else if (load) begin
      pend_o    <= 1'b0;
    end
  end

  assign lvl   = cfg_i.en && !hold && (cfg_i.bypass ? pclk : (cnt_q < dty_q));
  assign pwm_o = cfg_i.act ? lvl : ~lvl;

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= prd_q);

  // R4
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dty_q == '0 && !cfg_i.bypass && cfg_i.act) |-> !pwm_o);

  // R6
  gate_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && !cfg_i.gate && !hold) |=> $stable(cnt_q));

  // R7
  idle_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && pend_o && !prd_wr_i) |=> !pend_o);

  // R10
  write_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_wr_i |=> pend_o);

  // R8
  oneshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (cnt_q == '0));

endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 17,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCH-1:0]    pwm_o
);

  localparam int FLD_W = $bits(ch_ctrl_t);

  logic        ctrl_wr;
  logic [31:0] ctrl_part [NCH];
  logic [31:0] prd_word  [NCH];
  logic        unused_wdata;

  assign ctrl_wr      = we_i && (addr_i == '0);
  assign unused_wdata = ^wdata_i;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    ch_ctrl_t         cfg_q;
    logic             prd_wr, pend, done;
    logic [CNT_W-1:0] shp, shd;

    assign prd_wr = we_i && (addr_i == ADDR_W'(n + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cfg_q       <= '0;
      else if (ctrl_wr) cfg_q       <= ch_ctrl_t'(wdata_i[n*CH_STRIDE +: FLD_W]);
      else if (done)    cfg_q.pulse <= 1'b0;
    end

    pwm2_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_i     (cfg_q),
      .prd_wr_i  (prd_wr),
      .prd_i     (wdata_i[PRD_LSB +: CNT_W]),
      .dty_i     (wdata_i[0 +: CNT_W]),
      .pwm_o     (pwm_o[n]),
      .pend_o    (pend),
      .done_o    (done),
      .shd_prd_o (shp),
      .shd_dty_o (shd)
    );

    assign ctrl_part[n] = (32'(cfg_q) << (n*CH_STRIDE)) | (32'(pend) << (RDY_BASE + n));
    assign prd_word[n]  = (32'(shp) << PRD_LSB) | 32'(shd);

    // R8
    pulse_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done && !ctrl_wr) |=> !cfg_q.pulse);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      for (int n = 0; n < NCH; n++) rdata_o = rdata_o | ctrl_part[n];
    end else begin
      for (int n = 0; n < NCH; n++)
        if (addr_i == ADDR_W'(n + 1)) rdata_o = prd_word[n];
    end
  end

endmodule

// File: tb/sim_pwm2_ctrl.sv
module sim_pwm2_ctrl;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pwm;

  always #10 clk = ~clk;

  pwm2_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  int checks = 0, fails = 0;
  string cur_tag = "R1";

  // behavioural reference model
  int m_pres[2], m_en[2], m_act[2], m_gate[2], m_mode[2], m_pulse[2], m_byp[2];
  int m_pcnt[2], m_pclk[2], m_cnt[2], m_prdw[2], m_dtyw[2], m_shp[2], m_shd[2], m_pend[2];

  function automatic int mdiv(input int c);
    case (c)
      0: return 120;    1: return 180;    2: return 240;   3: return 360;
      4: return 480;    8: return 12000;  9: return 24000; 10: return 36000;
      11: return 48000; 12: return 72000; 15: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int mexp(input int n);
    int lvl;
    lvl = (m_en[n] != 0 && (m_mode[n] == 0 || m_pulse[n] != 0)) ?
          (m_byp[n] != 0 ? m_pclk[n] : (m_cnt[n] < m_dtyw[n] ? 1 : 0)) : 0;
    return (m_act[n] != 0) ? lvl : 1 - lvl;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    for (int n = 0; n < 2; n++) begin
      int d, run, tick, eop, done, idle, load, w;
      if (!rst_n) begin
        m_pres[n]=0; m_en[n]=0; m_act[n]=0; m_gate[n]=0; m_mode[n]=0; m_pulse[n]=0; m_byp[n]=0;
        m_pcnt[n]=0; m_pclk[n]=0; m_cnt[n]=0; m_prdw[n]=0; m_dtyw[n]=0; m_shp[n]=0; m_shd[n]=0; m_pend[n]=0;
      end else begin
        d    = mdiv(m_pres[n]);
        run  = (m_en[n] != 0 && m_gate[n] != 0 && (m_mode[n] == 0 || m_pulse[n] != 0)) ? 1 : 0;
        tick = (run != 0 && d != 0 && m_pcnt[n] >= d - 1) ? 1 : 0;
        eop  = (tick != 0 && m_cnt[n] == m_prdw[n]) ? 1 : 0;
        done = (eop != 0 && m_mode[n] != 0 && m_pulse[n] != 0) ? 1 : 0;
        idle = (m_en[n] == 0 || (m_mode[n] != 0 && m_pulse[n] == 0)) ? 1 : 0;
        load = (m_pend[n] != 0 && (idle != 0 || eop != 0)) ? 1 : 0;
        if (m_en[n] == 0) begin m_pcnt[n] = 0; m_pclk[n] = 0; end
        else begin
          if (run != 0 && d != 0) m_pcnt[n] = (tick != 0) ? 0 : m_pcnt[n] + 1;
          if (tick != 0) m_pclk[n] = 1 - m_pclk[n];
        end
        if (idle != 0) m_cnt[n] = 0;
        else if (tick != 0) m_cnt[n] = (eop != 0) ? 0 : m_cnt[n] + 1;
        if (load != 0) begin m_prdw[n] = m_shp[n]; m_dtyw[n] = m_shd[n]; end
        if (we && addr == 2'(n + 1)) begin
          m_shp[n] = int'(wdata[23:16]); m_shd[n] = int'(wdata[7:0]); m_pend[n] = 1;
        end else if (load != 0) m_pend[n] = 0;
        if (we && addr == 2'd0) begin
          w = int'(wdata >> (15 * n));
          m_pres[n] = w & 15; m_en[n] = (w >> 4) & 1; m_act[n] = (w >> 5) & 1;
          m_gate[n] = (w >> 6) & 1; m_mode[n] = (w >> 7) & 1; m_pulse[n] = (w >> 8) & 1;
          m_byp[n] = (w >> 9) & 1;
        end else if (done != 0) m_pulse[n] = 0;
      end
    end
    #5;
    if (rst_n) begin
      for (int n = 0; n < 2; n++) begin
        chk(cur_tag, int'(pwm[n]), mexp(n));
        if (addr == 2'd0 && !we) chk("R7 pending", int'(rdata[28 + n]), m_pend[n]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
    @(negedge clk); addr = '0;
  endtask

  task automatic cnt_hi(input int ch, input int ncyc, output int c);
    c = 0;
    repeat (ncyc) begin #1 c += int'(pwm[ch]); @(negedge clk); end
  endtask

  logic done_flag = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int c, s, prev, tog;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 outputs", int'(pwm), 3);
    rd(2'd0, r); chk("R1 control", int'(r), 0);
    rd(2'd1, r); chk("R1 period0", int'(r), 0);
    rd(2'd2, r); chk("R1 period1", int'(r), 0);

    cur_tag = "R7";
    wr(2'd1, 32'h0003_0001);
    #1 chk("R7 pending set", int'(rdata[28]), 1);
    @(negedge clk); #1 chk("R7 idle load", int'(rdata[28]), 0);
    rd(2'd1, r); chk("R2 period readback", int'(r), 32'h0003_0001);

    cur_tag = "R4";
    wr(2'd0, 32'h7F);
    rd(2'd0, r); chk("R2 control readback", int'(r), 32'h7F);
    cnt_hi(0, 40, c); chk("R4 duty 1 of 4", c, 10);

    cur_tag = "R5";
    wr(2'd0, 32'h5F);
    cnt_hi(0, 40, c); chk("R5 inverted", c, 30);

    cur_tag = "R4";
    wr(2'd0, 32'h7F);
    wr(2'd1, 32'h0003_0000);
    #1 chk("R7 pending while running", int'(rdata[28]), 1);
    repeat (8) @(negedge clk);
    cnt_hi(0, 20, c); chk("R4 zero duty", c, 0);
    wr(2'd1, 32'h0003_0009);
    repeat (8) @(negedge clk);
    cnt_hi(0, 20, c); chk("R4 duty above period", c, 20);

    cur_tag = "R6";
    wr(2'd1, 32'h0003_0002);
    repeat (8) @(negedge clk);
    wr(2'd0, 32'h3F);
    #1 s = int'(pwm[0]);
    repeat (10) @(negedge clk);
    #1 chk("R6 gate freeze", int'(pwm[0]), s);
    wr(2'd0, 32'h6F);
    #1 chk("R6 disable inactive", int'(pwm[0]), 0);

    cur_tag = "R10";
    wr(2'd1, 32'h0003_0002);
    wr(2'd0, 32'h7F);
    do @(negedge clk); while (m_cnt[0] != m_prdw[0]);
    we = 1'b1; addr = 2'd1; wdata = 32'h0001_0000;
    @(negedge clk); we = 1'b0; addr = '0;
    #1 chk("R10 pending kept", int'(rdata[28]), 1);
    cnt_hi(0, 4, c); chk("R10 old value period", c, 2);
    cnt_hi(0, 4, c); chk("R10 new value period", c, 0);
    #1 chk("R10 pending cleared", int'(rdata[28]), 0);

    cur_tag = "R3";
    wr(2'd0, 32'h6F);
    wr(2'd2, 32'h0001_0001);
    wr(2'd0, 32'h71 << 15);
    rd(2'd0, r); chk("R2 channel 1 stride", int'(r), 32'h71 << 15);
    cnt_hi(1, 720, c); chk("R3 divide by 180", c, 360);
    wr(2'd0, 32'h75 << 15);
    #1 s = int'(pwm[1]);
    cnt_hi(1, 300, c); chk("R3 reserved code frozen", c, (s != 0) ? 300 : 0);

    cur_tag = "R9";
    wr(2'd0, 32'h27F << 15);
    #1 prev = int'(pwm[1]);
    tog = 0;
    repeat (10) begin
      @(negedge clk); #1;
      if (int'(pwm[1]) != prev) tog++;
      prev = int'(pwm[1]);
    end
    chk("R9 bypass toggles", tog, 10);
    rd(2'd0, r); chk("R2 bypass readback", int'(r), 32'h27F << 15);

    cur_tag = "R8";
    wr(2'd0, 32'hFF);
    wr(2'd1, 32'h0003_0002);
    #1 chk("R8 idle before trigger", int'(pwm[0]), 0);
    @(negedge clk); #1 chk("R7 load in one-shot idle", int'(rdata[28]), 0);
    wr(2'd0, 32'h1FF);
    cnt_hi(0, 20, c); chk("R8 single period", c, 2);
    rd(2'd0, r); chk("R8 trigger self-clears", int'(r[8]), 0);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule